// File: doc/BRIEF.md
# Pin Drive and Float Control Unit

This unit carries out one family of single-operand pin instructions for a bank of general-purpose I/O pins. Each instruction picks one pin and, in one step, either turns its output driver on (drive group) or off (float group). In the same step it gives the pin's output register bit a new value: a constant, the carry flag, the zero flag, the complement of either flag, the complement of the current bit, or the unchanged bit.

The execution stage sends a 32-bit instruction word with a valid strobe. It also sends the register operand, the current carry and zero flags and the sampled pin inputs. The direction and output registers live in this unit and change on the clock edge that ends the instruction's cycle. Flag write-back is combinational in the instruction's cycle. It returns the selected pin's input as it was before the instruction, so the execution stage can load its carry and/or zero flag. Selection of the pin index depends on the immediate bit: the index comes either from the instruction's own operand field or from the register operand.

Top module: `pinctl_unit`

## Requirements
- R1: While reset is asserted, and after it is released, every direction bit and every output bit reads 0. Reset is asynchronous and active low, and release is synchronised internally over two clock edges.
- R2: An accepted instruction with minor code 0_0101_0mmm (float group, bit 3 = 0) clears the direction bit of the selected pin at the next clock edge.
- R3: An accepted instruction with minor code 0_0101_1mmm (drive group, bit 3 = 1) sets the direction bit of the selected pin at the next clock edge.
- R4: Output mode mmm = 000 writes 0 and mmm = 001 writes 1 into the selected output bit.
- R5: Output mode 010 writes the carry flag input, and 011 writes its complement.
- R6: Output mode 100 writes the zero flag input, and 101 writes its complement.
- R7: Output mode 110 inverts the selected output bit.
- R8: Output mode 111 leaves every output bit unchanged, while the direction bit still follows its group.
- R9: When instruction bit 18 (immediate) is 1, the pin index is the low 6 bits of the instruction's D field, bits 17:9. When bit 18 is 0, it is the low 6 bits of the register operand. Higher operand bits are ignored.
- R10: In the cycle of an accepted instruction, bit 20 (carry write) raises the carry write enable, and bit 19 (zero write) raises the zero write enable. Each enable carries the selected pin's input value, sampled before the direction change.
- R11: Only the selected pin's direction and output bits can change. Both commit on the same clock edge.
- R12: A word whose bits 27:21 are not 1101011, a minor code outside the two groups, or a deasserted valid strobe changes no register and raises no flag write enable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_valid | input | 1 | Instruction word is present this cycle |
| instr | input | 32 | Instruction word |
| operand | input | 32 | Register operand used when the immediate bit is 0 |
| carry_in | input | 1 | Current carry flag |
| zero_in | input | 1 | Current zero flag |
| pin_in | input | 64 | Sampled pin inputs |
| dir_q | output | 64 | Direction register (1 = driven) |
| out_q | output | 64 | Output register |
| carry_we | output | 1 | Carry flag write enable |
| carry_wdata | output | 1 | New carry value |
| zero_we | output | 1 | Zero flag write enable |
| zero_wdata | output | 1 | New zero value |

## Verification
A wrong internal state here shows up directly at the ports. The direction and output registers are the ports themselves, so a bad group decode, mode selection or pin index shows as a wrong bit in dir_q or out_q one edge after the instruction. A pin other than the intended one changing shows in the same place. Flag errors show in the same cycle as the instruction on the write enables and write data. The bench keeps a full 64-bit mirror of both registers and compares every bit after each instruction, so a stray write to an unselected pin cannot go unseen.

// File: rtl/pinctl_pkg.sv
package pinctl_pkg;
  localparam int unsigned INSTR_W  = 32;
  localparam int unsigned DFIELD_W = 9;
  localparam logic [6:0]  MAJOR_PIN = 7'b1101011;
  localparam logic [4:0]  MINOR_HI  = 5'b00101;

  typedef enum logic [2:0] {
    OM_LOW    = 3'd0,
    OM_HIGH   = 3'd1,
    OM_CARRY  = 3'd2,
    OM_NCARRY = 3'd3,
    OM_ZERO   = 3'd4,
    OM_NZERO  = 3'd5,
    OM_TOGGLE = 3'd6,
    OM_KEEP   = 3'd7
  } out_mode_e;

  typedef struct packed {
    logic                fire;
    logic                drive;
    out_mode_e           mode;
    logic                wr_c;
    logic                wr_z;
    logic                imm;
    logic [DFIELD_W-1:0] dfield;
  } pin_cmd_t;
endpackage

// File: rtl/pinctl_decode.sv
module pinctl_decode
  import pinctl_pkg::*;
(
  input  logic               valid,
  input  logic [INSTR_W-1:0] instr,
  output pin_cmd_t           cmd
);
  logic major_ok;
  logic minor_ok;

  always_comb begin
    major_ok   = (instr[27:21] == MAJOR_PIN);
    minor_ok   = (instr[8:4] == MINOR_HI);
    cmd.fire   = valid && major_ok && minor_ok;
    cmd.drive  = instr[3];
    cmd.mode   = out_mode_e'(instr[2:0]);
    cmd.wr_c   = instr[20];
    cmd.wr_z   = instr[19];
    cmd.imm    = instr[18];
    cmd.dfield = instr[17:9];
  end

  // Decode sanity: an accepted word always belongs to the pin family (R12)
  always_comb begin
    if (cmd.fire) begin
      a_family_r12: assert (instr[27:21] == MAJOR_PIN && instr[8:4] == MINOR_HI)
        else $error("decode accepted a foreign word");
    end
  end
endmodule

// File: rtl/pinctl_outsel.sv
module pinctl_outsel
  import pinctl_pkg::*;
(
  input  out_mode_e mode,
  input  logic      cur_bit,
  input  logic      carry,
  input  logic      zero,
  output logic      new_bit
);
  always_comb begin
    unique case (mode)
      OM_LOW:    new_bit = 1'b0;
      OM_HIGH:   new_bit = 1'b1;
      OM_CARRY:  new_bit = carry;
      OM_NCARRY: new_bit = ~carry;
      OM_ZERO:   new_bit = zero;
      OM_NZERO:  new_bit = ~zero;
      OM_TOGGLE: new_bit = ~cur_bit;
      default:   new_bit = cur_bit;
    endcase
  end
endmodule

// File: rtl/pinctl_unit.sv
module pinctl_unit
  import pinctl_pkg::*;
#(
  parameter int unsigned NPINS = 64,
  parameter int unsigned OP_W  = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               instr_valid,
  input  logic [INSTR_W-1:0] instr,
  input  logic [OP_W-1:0]    operand,
  input  logic               carry_in,
  input  logic               zero_in,
  input  logic [NPINS-1:0]   pin_in,
  output logic [NPINS-1:0]   dir_q,
  output logic [NPINS-1:0]   out_q,
  output logic               carry_we,
  output logic               carry_wdata,
  output logic               zero_we,
  output logic               zero_wdata
);
  localparam int unsigned IDX_W = $clog2(NPINS);

  // Reset: asynchronous assert, synchronous release
  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic                   rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[SYNC_STAGES-1];

  // Decode
  pin_cmd_t cmd;
  pinctl_decode u_dec (
    .valid (instr_valid & rst_int_n),
    .instr (instr),
    .cmd   (cmd)
  );

  // Pin index selection
  logic [IDX_W-1:0] pin_idx;
  always_comb begin
    if (cmd.imm) pin_idx = cmd.dfield[IDX_W-1:0];
    else         pin_idx = operand[IDX_W-1:0];
  end

  // Output value selection
  logic new_out;
  pinctl_outsel u_sel (
    .mode    (cmd.mode),
    .cur_bit (out_q[pin_idx]),
    .carry   (carry_in),
    .zero    (zero_in),
    .new_bit (new_out)
  );

  // Flag write-back: pin state before this instruction
  always_comb begin
    carry_we    = cmd.fire && cmd.wr_c;
    zero_we     = cmd.fire && cmd.wr_z;
    carry_wdata = pin_in[pin_idx];
    zero_wdata  = pin_in[pin_idx];
  end

  // Next state
  logic [NPINS-1:0] dir_d;
  logic [NPINS-1:0] out_d;
  always_comb begin
    dir_d = dir_q;
    out_d = out_q;
    dir_d[pin_idx] = cmd.drive;
    out_d[pin_idx] = new_out;
  end

  // Registers, enabled by an accepted instruction
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '0;
      out_q <= '0;
    end else if (!rst_int_n) begin
      dir_q <= '0;
      out_q <= '0;
    end else if (cmd.fire) begin
      dir_q <= dir_d;
      out_q <= out_d;
    end
  end

  // Assertions
  p_one_dir_bit_r11: assert property (@(posedge clk) disable iff (!rst_n || !rst_int_n)
    $countones(dir_q ^ $past(dir_q)) <= 1)
    else $error("more than one direction bit changed");

  p_one_out_bit_r11: assert property (@(posedge clk) disable iff (!rst_n || !rst_int_n)
    $countones(out_q ^ $past(out_q)) <= 1)
    else $error("more than one output bit changed");

  p_float_clears_r2: assert property (@(posedge clk) disable iff (!rst_n || !rst_int_n)
    (cmd.fire && !cmd.drive) |=> !dir_q[$past(pin_idx)])
    else $error("float did not clear direction");

  p_drive_sets_r3: assert property (@(posedge clk) disable iff (!rst_n || !rst_int_n)
    (cmd.fire && cmd.drive) |=> dir_q[$past(pin_idx)])
    else $error("drive did not set direction");

  p_keep_out_r8: assert property (@(posedge clk) disable iff (!rst_n || !rst_int_n)
    (cmd.fire && cmd.mode == OM_KEEP) |=> $stable(out_q))
    else $error("keep mode changed output");

  p_idle_stable_r12: assert property (@(posedge clk) disable iff (!rst_n || !rst_int_n)
    !cmd.fire |=> ($stable(dir_q) && $stable(out_q)))
    else $error("registers changed without an accepted instruction");

  p_idle_noflag_r12: assert property (@(posedge clk) disable iff (!rst_n || !rst_int_n)
    !cmd.fire |-> (!carry_we && !zero_we))
    else $error("flag write without an accepted instruction");
endmodule

// File: tb/pinctl_unit_tb_top.sv
module pinctl_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        instr_valid = 1'b0;
  logic [31:0] instr = '0;
  logic [31:0] operand = '0;
  logic        carry_in = 1'b0;
  logic        zero_in = 1'b0;
  logic [63:0] pin_in = '0;
  logic [63:0] dir_q;
  logic [63:0] out_q;
  logic        carry_we, carry_wdata, zero_we, zero_wdata;

  int checks = 0;
  int errors = 0;
  logic [63:0] exp_dir = '0;
  logic [63:0] exp_out = '0;
  logic        cap_cwe, cap_cwd, cap_zwe, cap_zwd;

  always #5 clk = ~clk;

  pinctl_unit dut_i (
    .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr(instr),
    .operand(operand), .carry_in(carry_in), .zero_in(zero_in), .pin_in(pin_in),
    .dir_q(dir_q), .out_q(out_q), .carry_we(carry_we), .carry_wdata(carry_wdata),
    .zero_we(zero_we), .zero_wdata(zero_wdata)
  );

  // Vector: {req[3:0], drive, mode[2:0], pin[5:0], carry, zero, exp_dir, exp_out}
  localparam int NV = 12;
  localparam logic [17:0] VEC [0:NV-1] = '{
    {4'd3, 1'b1, 3'd1, 6'd5,  1'b0, 1'b0, 1'b1, 1'b1}, // R3 R4 drive high
    {4'd4, 1'b1, 3'd0, 6'd5,  1'b0, 1'b0, 1'b1, 1'b0}, // R4 drive low
    {4'd2, 1'b0, 3'd2, 6'd7,  1'b1, 1'b0, 1'b0, 1'b1}, // R2 R5 float carry
    {4'd5, 1'b0, 3'd3, 6'd7,  1'b1, 1'b0, 1'b0, 1'b0}, // R5 float not-carry
    {4'd6, 1'b1, 3'd4, 6'd63, 1'b0, 1'b1, 1'b1, 1'b1}, // R6 drive zero
    {4'd6, 1'b1, 3'd5, 6'd63, 1'b0, 1'b1, 1'b1, 1'b0}, // R6 drive not-zero
    {4'd7, 1'b1, 3'd6, 6'd0,  1'b0, 1'b0, 1'b1, 1'b1}, // R7 toggle 0->1
    {4'd7, 1'b0, 3'd6, 6'd0,  1'b0, 1'b0, 1'b0, 1'b0}, // R7 toggle 1->0
    {4'd8, 1'b1, 3'd7, 6'd5,  1'b1, 1'b1, 1'b1, 1'b0}, // R8 keep, drive
    {4'd4, 1'b1, 3'd1, 6'd40, 1'b0, 1'b0, 1'b1, 1'b1}, // R4 drive high
    {4'd8, 1'b0, 3'd7, 6'd40, 1'b0, 1'b0, 1'b0, 1'b1}, // R8 keep, float
    {4'd5, 1'b1, 3'd3, 6'd12, 1'b0, 1'b1, 1'b1, 1'b1}  // R5 not-carry with carry 0
  };

  function automatic logic [31:0] mk(input logic drv, input logic [2:0] mode,
                                     input logic wc, input logic wz,
                                     input logic imm, input logic [8:0] d);
    return {4'hF, 7'b1101011, wc, wz, imm, d, 5'b00101, drv, mode};
  endfunction

  task automatic chk(input logic ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Apply one word for one cycle; flags captured before the edge, registers after
  task automatic run(input logic v, input logic [31:0] w, input logic [31:0] op,
                     input logic c, input logic z, input logic [63:0] pins);
    @(negedge clk);
    instr_valid = v; instr = w; operand = op;
    carry_in = c; zero_in = z; pin_in = pins;
    #1;
    cap_cwe = carry_we; cap_cwd = carry_wdata;
    cap_zwe = zero_we;  cap_zwd = zero_wdata;
    @(posedge clk);
    #1;
    instr_valid = 1'b0;
  endtask

  task automatic chk_regs(input string req);
    chk(dir_q == exp_dir, req, dir_q, exp_dir);
    chk(out_q == exp_out, req, out_q, exp_out);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R1: reset state, held and after release
    repeat (3) @(posedge clk);
    #1;
    chk(dir_q == '0, "R1 dir during reset", dir_q, '0);
    chk(out_q == '0, "R1 out during reset", out_q, '0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    chk_regs("R1 after release");

    // Vector table
    for (int i = 0; i < NV; i++) begin
      logic [17:0] v;
      string tag;
      v = VEC[i];
      tag = $sformatf("R%0d vector %0d", v[17:14], i);
      run(1'b1, mk(v[13], v[12:10], 1'b0, 1'b0, 1'b1, {3'b000, v[9:4]}),
          32'hDEAD_BEEF, v[3], v[2], '0);
      exp_dir[v[9:4]] = v[1];
      exp_out[v[9:4]] = v[0];
      chk_regs(tag);
      chk(!cap_cwe && !cap_zwe, "R10 no flag write", {62'd0, cap_cwe, cap_zwe}, '0);
    end

    // R9: register operand, high bits ignored, D field not used
    run(1'b1, mk(1'b1, 3'd1, 1'b0, 1'b0, 1'b0, 9'd9), 32'hFFFF_FFC3, 1'b0, 1'b0, '0);
    exp_dir[3] = 1'b1; exp_out[3] = 1'b1;
    chk_regs("R9 operand index");
    // R9: immediate with bits above index width set in D
    run(1'b1, mk(1'b1, 3'd1, 1'b0, 1'b0, 1'b1, 9'h1C2), 32'h0000_0011, 1'b0, 1'b0, '0);
    exp_dir[2] = 1'b1; exp_out[2] = 1'b1;
    chk_regs("R9 immediate index");

    // R10: both flags, selected pin high, others low
    run(1'b1, mk(1'b0, 3'd7, 1'b1, 1'b1, 1'b1, 9'd20), '0, 1'b0, 1'b0, 64'h1 << 20);
    chk(cap_cwe && cap_cwd, "R10 carry write", {62'd0, cap_cwe, cap_cwd}, 64'h3);
    chk(cap_zwe && cap_zwd, "R10 zero write", {62'd0, cap_zwe, cap_zwd}, 64'h3);
    chk_regs("R10 regs");
    // R10: carry only, selected pin low, all others high, pin driven before
    run(1'b1, mk(1'b0, 3'd0, 1'b1, 1'b0, 1'b1, 9'd5), '0, 1'b0, 1'b0, ~(64'h1 << 5));
    exp_dir[5] = 1'b0; exp_out[5] = 1'b0;
    chk(cap_cwe && !cap_cwd && !cap_zwe, "R10 carry only",
        {61'd0, cap_cwe, cap_cwd, cap_zwe}, 64'h4);
    chk_regs("R10 float after sample");

    // R12: foreign major, foreign minor, no valid
    run(1'b1, {4'hF, 7'b1101010, 1'b1, 1'b1, 1'b1, 9'd33, 9'b001011001}, '0, 1'b1, 1'b1, '1);
    chk(!cap_cwe && !cap_zwe, "R12 major flags", {62'd0, cap_cwe, cap_zwe}, '0);
    chk_regs("R12 foreign major");
    run(1'b1, {4'hF, 7'b1101011, 1'b1, 1'b1, 1'b1, 9'd33, 9'b001100001}, '0, 1'b1, 1'b1, '1);
    chk(!cap_cwe && !cap_zwe, "R12 minor flags", {62'd0, cap_cwe, cap_zwe}, '0);
    chk_regs("R12 foreign minor");
    run(1'b0, mk(1'b1, 3'd1, 1'b1, 1'b1, 1'b1, 9'd33), '0, 1'b1, 1'b1, '1);
    chk(!cap_cwe && !cap_zwe, "R12 idle flags", {62'd0, cap_cwe, cap_zwe}, '0);
    chk_regs("R12 valid low");

    // R1: reset asserted mid-run clears everything at once
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    exp_dir = '0; exp_out = '0;
    chk_regs("R1 mid-run reset");
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    chk_regs("R1 second release");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule